// File: doc/BRIEF.md
# Phase-Table PWM with Safety Override

This block turns an angular position into eight PWM pad controls. The position, 32 bits covering one electrical turn, is offset by a per-pair angle shift. It is then scaled by a programmable sector count, which gives a table row for each pair of outputs. Each row holds a 2-bit force code per output. The code either lets an external PWM waveform through or pins the output low or high. Two banks of rows exist, a positive and a negative one, and a select input picks the bank that is read.

A safety override sits above the table path. It is active while a software request is held, or while a latched hardware trip is set. The latch sets on an unshielded trigger and clears as soon as the trigger source drops. In safety mode every output follows a separate safety table that can drive low, drive high or release the pad (drive-enable low). A pair-swap option exchanges the table-path values of outputs 2k and 2k+1. A global enable pins all outputs low when safety is not active.

Top module: `phase_table_pwm`

## Requirements
- R1: On every clock edge the sector of pair k (sector_o bits [3k+2:3k]) is loaded with (((pos_i + shift_i[32k+31:32k]) mod 2^32) * n) >> 32, where n = phase_num_i clamped to at most 8. A count of 0 or 1 gives sector 0.
- R2: The table code of output j is bits [2j+1:2j] of the row selected by its pair's sector. Code 2 drives 0, code 3 drives 1, and codes 0 and 1 pass pwm_i[j]. Drive-enable is 1 on the table path.
- R3: tbl_neg_sel_i = 0 reads the positive bank and 1 reads the negative bank. A row write (row_bank_i: 0 positive, 1 negative) changes only its own bank.
- R4: With pair_swap_i = 1, output 2k shows the table-path value computed for output 2k+1, and output 2k+1 shows the value for output 2k.
- R5: With enable_i = 0 and safety inactive, all pwm_o are 0 and all pwm_oe_o are 1.
- R6: While safety is active (safe_o = sw_safe_i OR hw_safe_o), output j follows safety code bits [2j+1:2j]. Code 0 drives 0 with enable 1, code 1 drives 1 with enable 1, and codes 2 and 3 give pwm_o 0 with pwm_oe_o 0. Safety overrides enable, table, swap and pwm_i.
- R7: hw_safe_o sets on an edge where hw_trig_i = 1 and hw_shield_i = 0, and clears on an edge where hw_trig_i = 0. Raising the shield while the latch is set does not clear it.
- R8: sw_safe_i acts within the same cycle, and clearing it leaves safety mode unless hw_safe_o is set.
- R9: A row or safety-table write takes effect on the clock edge that accepts it, so outputs sampled after that edge reflect it.
- R10: After reset all rows of both banks are 0 (pass-through), the safety table holds code 2 on every output, every sector is 0 and hw_safe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_i | input | 32 | Angular position, full scale = one turn |
| shift_i | input | 128 | Four 32-bit angle offsets, pair k at [32k+31:32k] |
| phase_num_i | input | 4 | Sector count per turn, clamped to 8 |
| tbl_neg_sel_i | input | 1 | Bank read select: 0 positive, 1 negative |
| pair_swap_i | input | 1 | Exchange table-path values within each output pair |
| enable_i | input | 1 | Global output enable |
| pwm_i | input | 8 | External PWM passed through by codes 0 and 1 |
| row_we_i | input | 1 | Phase-table row write strobe |
| row_bank_i | input | 1 | Bank written: 0 positive, 1 negative |
| row_addr_i | input | 3 | Row written |
| row_data_i | input | 16 | Row contents, output j at [2j+1:2j] |
| safe_we_i | input | 1 | Safety-table write strobe |
| safe_data_i | input | 16 | Safety codes, output j at [2j+1:2j] |
| sw_safe_i | input | 1 | Software safety request |
| hw_trig_i | input | 1 | Hardware safety trigger |
| hw_shield_i | input | 1 | Masks the hardware trigger |
| pwm_o | output | 8 | Output drive values |
| pwm_oe_o | output | 8 | Output drive enables |
| sector_o | output | 12 | Current sector per pair, 3 bits each |
| safe_o | output | 1 | Safety mode active |
| hw_safe_o | output | 1 | Hardware-entered safety latch |

## Verification
The sweep walks every sector count from 0 to 9 against positions that include 0, all-ones and exact sector boundaries. The shifts wrap past 2^32, so a design that clamps the sum, forgets to clamp the count or rounds the product would put a pair in the wrong row. The table pass-through, pair swap and bank select are toggled together with the sweep, which catches a swap applied to the pwm_i source instead of to the table value, or a write landing in the wrong bank. The hardware trip is tried shielded, unshielded, shielded after latching and with the software request dropped while latched. A design that ignores the shield, clears the latch on the shield or leaves safety on the software bit alone is caught there.

// File: rtl/ptp_pkg.sv
// Package: shared code values for the phase-table PWM block.
// Assumes 2-bit codes per output in both the phase and the safety tables.
package ptp_pkg;

    // Force codes held in phase-table rows
    typedef enum logic [1:0] {
        PH_FREE = 2'd0,
        PH_RSVD = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } ph_code_e;

    // Codes held in the safety table
    typedef enum logic [1:0] {
        SF_LOW  = 2'd0,
        SF_HIGH = 2'd1,
        SF_HIZ  = 2'd2,
        SF_HIZ2 = 2'd3
    } sf_code_e;

    localparam int CODE_W = 2;

endpackage

// File: rtl/ptp_sector_calc.sv
// Module: ptp_sector_calc
// Adds an angle offset to the position, scales by the clamped sector count
// and registers the integer part as the sector index.
// Assumes ROWS >= 2; counts above ROWS are clamped to ROWS.
module ptp_sector_calc #(
    parameter  int POS_W  = 32,
    parameter  int ROWS   = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int CNT_W  = $clog2(ROWS + 1),
    localparam int PROD_W = POS_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] shift_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [ROW_W-1:0] sector_q
);

    logic [POS_W-1:0]  turned;
    logic [CNT_W-1:0]  used_cnt;
    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  whole;
    logic [POS_W-1:0]  unused_frac;

    // Offset, clamp and scale the position; split integer and fraction
    always_comb begin
        turned   = pos_i + shift_i;
        used_cnt = (count_i > CNT_W'(ROWS)) ? CNT_W'(ROWS) : count_i;
        prod     = PROD_W'(turned) * PROD_W'(used_cnt);
        {whole, unused_frac} = prod;
    end

    // Register the sector index, saturating defensively at the last row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector_q <= '0;
        end else if (whole >= CNT_W'(ROWS)) begin
            sector_q <= ROW_W'(ROWS - 1);
        end else begin
            sector_q <= whole[ROW_W-1:0];
        end
    end

endmodule

// File: rtl/ptp_phase_tables.sv
// Module: ptp_phase_tables
// Holds the positive and negative banks of force rows and returns, for each
// output, the code from the row selected by its pair's sector.
// Assumes an even output count; writes to addresses >= ROWS are dropped.
module ptp_phase_tables #(
    parameter  int NOUT  = 8,
    parameter  int ROWS  = 8,
    localparam int PAIRS = NOUT / 2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int ENT_W = 2 * NOUT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic                   bank_i,
    input  logic [ROW_W-1:0]       addr_i,
    input  logic [ENT_W-1:0]       data_i,
    input  logic                   neg_sel_i,
    input  logic [PAIRS*ROW_W-1:0] sector_i,
    output logic [ENT_W-1:0]       codes_o
);

    logic [ENT_W-1:0] bank_pos [ROWS];
    logic [ENT_W-1:0] bank_neg [ROWS];
    logic             addr_ok;

    // Guard against addresses beyond the configured row count
    always_comb addr_ok = ({1'b0, addr_i} < (ROW_W + 1)'(ROWS));

    // Clear both banks on reset, otherwise store one row into the chosen bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                bank_pos[r] <= '0;
                bank_neg[r] <= '0;
            end
        end else if (we_i && addr_ok) begin
            if (bank_i) begin
                bank_neg[addr_i] <= data_i;
            end else begin
                bank_pos[addr_i] <= data_i;
            end
        end
    end

    // Per output: read its code from the row addressed by its pair's sector
    for (genvar j = 0; j < NOUT; j++) begin : g_rd
        logic [ROW_W-1:0] idx;
        assign idx = sector_i[(j/2)*ROW_W +: ROW_W];
        assign codes_o[2*j +: 2] = neg_sel_i ? bank_neg[idx][2*j +: 2]
                                             : bank_pos[idx][2*j +: 2];
    end

endmodule

// File: rtl/ptp_safety_ctrl.sv
// Module: ptp_safety_ctrl
// Latches the hardware trip, combines it with the software request and
// holds the safety table.
// Assumes the trip source stays high until it is cleared upstream.
module ptp_safety_ctrl #(
    parameter  int NOUT  = 8,
    localparam int ENT_W = 2 * NOUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_trig_i,
    input  logic             hw_shield_i,
    input  logic             sw_safe_i,
    input  logic             tbl_we_i,
    input  logic [ENT_W-1:0] tbl_data_i,
    output logic             latch_o,
    output logic             safe_o,
    output logic [ENT_W-1:0] table_o
);

    import ptp_pkg::*;

    logic [ENT_W-1:0] reset_tbl;

    // Reset image: every output released (code 2)
    always_comb begin
        for (int j = 0; j < NOUT; j++) begin
            reset_tbl[2*j +: 2] = SF_HIZ;
        end
    end

    // Hardware trip latch: set on unshielded trigger, clear when source drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= 1'b0;
        end else if (hw_trig_i && !hw_shield_i) begin
            latch_o <= 1'b1;
        end else if (!hw_trig_i) begin
            latch_o <= 1'b0;
        end
    end

    // Safety table register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_o <= reset_tbl;
        end else if (tbl_we_i) begin
            table_o <= tbl_data_i;
        end
    end

    // Safety is active on either source
    always_comb safe_o = sw_safe_i | latch_o;

endmodule

// File: rtl/ptp_out_mux.sv
// Module: ptp_out_mux
// Resolves table codes against the external PWM, applies the pair swap,
// the global enable and the safety override into drive / drive-enable pairs.
// Assumes an even output count.
module ptp_out_mux #(
    parameter  int NOUT  = 8,
    localparam int ENT_W = 2 * NOUT
) (
    input  logic [ENT_W-1:0] codes_i,
    input  logic [NOUT-1:0]  pwm_i,
    input  logic             swap_i,
    input  logic             enable_i,
    input  logic             safe_i,
    input  logic [ENT_W-1:0] safe_tbl_i,
    output logic [NOUT-1:0]  pwm_o,
    output logic [NOUT-1:0]  oe_o
);

    import ptp_pkg::*;

    logic [NOUT-1:0] table_val;
    logic [NOUT-1:0] swapped;

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        logic [1:0] code;
        logic [1:0] scode;
        assign code  = codes_i[2*j +: 2];
        assign scode = safe_tbl_i[2*j +: 2];

        // Table path: forced level or external waveform
        always_comb begin
            if (code == PH_LOW) begin
                table_val[j] = 1'b0;
            end else if (code == PH_HIGH) begin
                table_val[j] = 1'b1;
            end else begin
                table_val[j] = pwm_i[j];
            end
        end

        // Optional exchange with the partner output of the pair
        always_comb swapped[j] = swap_i ? table_val[j ^ 1] : table_val[j];

        // Final priority: safety, then enable, then table path
        always_comb begin
            if (safe_i) begin
                pwm_o[j] = (scode == SF_HIGH);
                oe_o[j]  = (scode == SF_LOW) || (scode == SF_HIGH);
            end else if (!enable_i) begin
                pwm_o[j] = 1'b0;
                oe_o[j]  = 1'b1;
            end else begin
                pwm_o[j] = swapped[j];
                oe_o[j]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/phase_table_pwm.sv
// Module: phase_table_pwm (top)
// Eight-output phase-table PWM: per-pair sector lookup into a positive or
// negative force table, pair swap, global enable and a safety override.
// Assumes positions in full-turn 32-bit encoding and an even output count.
module phase_table_pwm #(
    parameter  int NOUT  = 8,
    parameter  int ROWS  = 8,
    parameter  int POS_W = 32,
    localparam int PAIRS = NOUT / 2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(ROWS + 1),
    localparam int ENT_W = 2 * NOUT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [POS_W-1:0]       pos_i,
    input  logic [PAIRS*POS_W-1:0] shift_i,
    input  logic [CNT_W-1:0]       phase_num_i,
    input  logic                   tbl_neg_sel_i,
    input  logic                   pair_swap_i,
    input  logic                   enable_i,
    input  logic [NOUT-1:0]        pwm_i,
    input  logic                   row_we_i,
    input  logic                   row_bank_i,
    input  logic [ROW_W-1:0]       row_addr_i,
    input  logic [ENT_W-1:0]       row_data_i,
    input  logic                   safe_we_i,
    input  logic [ENT_W-1:0]       safe_data_i,
    input  logic                   sw_safe_i,
    input  logic                   hw_trig_i,
    input  logic                   hw_shield_i,
    output logic [NOUT-1:0]        pwm_o,
    output logic [NOUT-1:0]        pwm_oe_o,
    output logic [PAIRS*ROW_W-1:0] sector_o,
    output logic                   safe_o,
    output logic                   hw_safe_o
);

    logic [ENT_W-1:0] codes;
    logic [ENT_W-1:0] safe_tbl;

    // One sector calculator per output pair, each with its own offset
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        ptp_sector_calc #(.POS_W(POS_W), .ROWS(ROWS)) u_sec (
            .clk      (clk),
            .rst_n    (rst_n),
            .pos_i    (pos_i),
            .shift_i  (shift_i[k*POS_W +: POS_W]),
            .count_i  (phase_num_i),
            .sector_q (sector_o[k*ROW_W +: ROW_W])
        );
    end

    ptp_phase_tables #(.NOUT(NOUT), .ROWS(ROWS)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (row_we_i),
        .bank_i    (row_bank_i),
        .addr_i    (row_addr_i),
        .data_i    (row_data_i),
        .neg_sel_i (tbl_neg_sel_i),
        .sector_i  (sector_o),
        .codes_o   (codes)
    );

    ptp_safety_ctrl #(.NOUT(NOUT)) u_safe (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_trig_i   (hw_trig_i),
        .hw_shield_i (hw_shield_i),
        .sw_safe_i   (sw_safe_i),
        .tbl_we_i    (safe_we_i),
        .tbl_data_i  (safe_data_i),
        .latch_o     (hw_safe_o),
        .safe_o      (safe_o),
        .table_o     (safe_tbl)
    );

    ptp_out_mux #(.NOUT(NOUT)) u_mux (
        .codes_i    (codes),
        .pwm_i      (pwm_i),
        .swap_i     (pair_swap_i),
        .enable_i   (enable_i),
        .safe_i     (safe_o),
        .safe_tbl_i (safe_tbl),
        .pwm_o      (pwm_o),
        .oe_o       (pwm_oe_o)
    );

endmodule

// File: rtl/ptp_pwm_chk.sv
// Module: ptp_pwm_chk
// Property checker attached to phase_table_pwm through bind.
module ptp_pwm_chk #(
    parameter int NOUT  = 8,
    parameter int SEC_W = 12,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] phase_num_i,
    input logic             enable_i,
    input logic             sw_safe_i,
    input logic             hw_trig_i,
    input logic             hw_shield_i,
    input logic [NOUT-1:0]  pwm_o,
    input logic [NOUT-1:0]  pwm_oe_o,
    input logic [SEC_W-1:0] sector_o,
    input logic             hw_safe_o
);

    // R7
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig_i && !hw_shield_i) |=> hw_safe_o);

    // R7
    hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_trig_i |=> !hw_safe_o);

    // R7
    hw_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_safe_o) |-> $past(hw_trig_i && !hw_shield_i));

    // R6
    release_only_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe_o != '1) |-> (sw_safe_i || hw_safe_o));

    // R6
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o & ~pwm_oe_o) == '0);

    // R5
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !sw_safe_i && !hw_safe_o) |-> (pwm_o == '0 && pwm_oe_o == '1));

    // R1
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_num_i) <= CNT_W'(1)) |-> (sector_o == '0));

endmodule

bind phase_table_pwm ptp_pwm_chk #(
    .NOUT  (NOUT),
    .SEC_W (PAIRS * ROW_W),
    .CNT_W (CNT_W)
) u_ptp_pwm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_num_i (phase_num_i),
    .enable_i    (enable_i),
    .sw_safe_i   (sw_safe_i),
    .hw_trig_i   (hw_trig_i),
    .hw_shield_i (hw_shield_i),
    .pwm_o       (pwm_o),
    .pwm_oe_o    (pwm_oe_o),
    .sector_o    (sector_o),
    .hw_safe_o   (hw_safe_o)
);

// File: tb/test_phase_table_pwm.sv
// Bench: sweeps sector counts, positions and modes of phase_table_pwm and
// compares every port against an arithmetic model.
module test_phase_table_pwm;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  pos = '0;
    logic [127:0] shift = '0;
    logic [3:0]   pnum = 4'd1;
    logic         nsel = 1'b0, swap = 1'b0, en = 1'b0;
    logic [7:0]   pwm_in = '0;
    logic         row_we = 1'b0, row_bank = 1'b0;
    logic [2:0]   row_addr = '0;
    logic [15:0]  row_data = '0;
    logic         safe_we = 1'b0;
    logic [15:0]  safe_data = '0;
    logic         sw_safe = 1'b0, hw_trig = 1'b0, hw_shield = 1'b0;

    logic [7:0]   pwm_o, pwm_oe_o;
    logic [11:0]  sector_o;
    logic         safe_o, hw_safe_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [15:0] m_pos [8];
    logic [15:0] m_neg [8];
    logic [15:0] m_stbl;
    logic        m_hw;
    logic [2:0]  m_sec [4];

    always #10 clk = ~clk;

    phase_table_pwm i_phase_table_pwm (
        .clk(clk), .rst_n(rst_n), .pos_i(pos), .shift_i(shift), .phase_num_i(pnum),
        .tbl_neg_sel_i(nsel), .pair_swap_i(swap), .enable_i(en), .pwm_i(pwm_in),
        .row_we_i(row_we), .row_bank_i(row_bank), .row_addr_i(row_addr), .row_data_i(row_data),
        .safe_we_i(safe_we), .safe_data_i(safe_data), .sw_safe_i(sw_safe),
        .hw_trig_i(hw_trig), .hw_shield_i(hw_shield), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o),
        .sector_o(sector_o), .safe_o(safe_o), .hw_safe_o(hw_safe_o)
    );

    function automatic logic [2:0] exp_sector(logic [31:0] p, logic [31:0] s, logic [3:0] n);
        logic [31:0] sum;
        logic [35:0] prod;
        logic [3:0]  nn;
        nn   = (n > 4'd8) ? 4'd8 : n;
        sum  = p + s;
        prod = {4'd0, sum} * {32'd0, nn};
        return prod[34:32];
    endfunction

    // Model update at an accepted clock edge
    task automatic model_edge();
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin m_pos[r] = '0; m_neg[r] = '0; end
            m_stbl = 16'hAAAA;
            m_hw = 1'b0;
            for (int k = 0; k < 4; k++) m_sec[k] = '0;
        end else begin
            if (row_we) begin
                if (row_bank) m_neg[row_addr] = row_data; else m_pos[row_addr] = row_data;
            end
            if (safe_we) m_stbl = safe_data;
            if (hw_trig && !hw_shield) m_hw = 1'b1;
            else if (!hw_trig) m_hw = 1'b0;
            for (int k = 0; k < 4; k++) m_sec[k] = exp_sector(pos, shift[32*k +: 32], pnum);
        end
    endtask

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // One clock: model the edge, then sample mid-cycle and compare all outputs
    task automatic tick(string tag);
        logic [7:0]  tp, sw, eo, eoe;
        logic [15:0] row;
        logic [1:0]  c;
        logic        sf;
        @(posedge clk);
        model_edge();
        #5;
        for (int j = 0; j < 8; j++) begin
            row = nsel ? m_neg[m_sec[j/2]] : m_pos[m_sec[j/2]];
            c = row[2*j +: 2];
            tp[j] = (c == 2'd2) ? 1'b0 : (c == 2'd3) ? 1'b1 : pwm_in[j];
        end
        for (int j = 0; j < 8; j++) sw[j] = swap ? tp[j ^ 1] : tp[j];
        sf = sw_safe | m_hw;
        for (int j = 0; j < 8; j++) begin
            c = m_stbl[2*j +: 2];
            if (sf) begin eo[j] = (c == 2'd1); eoe[j] = (c < 2'd2); end
            else if (!en) begin eo[j] = 1'b0; eoe[j] = 1'b1; end
            else begin eo[j] = sw[j]; eoe[j] = 1'b1; end
        end
        check(tag, "pwm_o", {8'd0, pwm_o}, {8'd0, eo});
        check(tag, "pwm_oe_o", {8'd0, pwm_oe_o}, {8'd0, eoe});
        check(tag, "sector_o", {4'd0, sector_o},
              {4'd0, m_sec[3], m_sec[2], m_sec[1], m_sec[0]});
        check(tag, "safe/hw", {14'd0, safe_o, hw_safe_o}, {14'd0, sf, m_hw});
    endtask

    task automatic write_row(string tag, logic bank, logic [2:0] a, logic [15:0] d);
        row_we = 1'b1; row_bank = bank; row_addr = a; row_data = d;
        tick(tag);
        row_we = 1'b0;
    endtask

    function automatic logic [15:0] row_pat(int r, int salt);
        logic [15:0] v;
        for (int j = 0; j < 8; j++) v[2*j +: 2] = 2'((r * salt + j + salt) % 4);
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #5;
        repeat (3) tick("R10");
        rst_n = 1'b1;
        // R10: reset image, pass-through rows and released safety outputs
        tick("R10");
        en = 1'b1; pwm_in = 8'hA5;
        tick("R10");
        sw_safe = 1'b1;
        tick("R10");
        sw_safe = 1'b0;

        // R9 / R3: fill both banks, a row write shows on the next sample
        pnum = 4'd0;
        for (int r = 0; r < 8; r++) write_row("R9", 1'b0, 3'(r), row_pat(r, 1));
        for (int r = 0; r < 8; r++) write_row("R3", 1'b1, 3'(r), row_pat(r, 3));

        // R1 boundaries at exact sector edges with eight sectors
        pnum = 4'd8;
        pos = 32'h1FFF_FFFF; tick("R1");
        pos = 32'h2000_0000; tick("R1");
        pos = 32'hFFFF_FFFF; tick("R1");
        shift = {32'hFFFF_FFFF, 32'h9000_0001, 32'h4000_0000, 32'h0000_0000};
        pos = 32'h0000_0001; tick("R1");

        // R1 / R2 / R3 / R4: sweep counts and positions with modes varying
        for (int n = 0; n < 10; n++) begin
            for (int p = 0; p < 48; p++) begin
                pnum   = 4'(n);
                pos    = (p == 47) ? 32'hFFFF_FFFF : 32'(p) * 32'h0555_5555 + 32'(n << 20);
                nsel   = p[1];
                swap   = p[0];
                pwm_in = 8'(p * 37 + n);
                tick((p % 2 == 1) ? "R4" : (nsel ? "R3" : "R2"));
            end
        end

        // R5: global enable low
        en = 1'b0; pwm_in = 8'hFF; tick("R5");
        pnum = 4'd5; pos = 32'h7000_0000; tick("R5");

        // R6 / R9: safety table patterns override enable, table and swap
        for (int t = 0; t < 6; t++) begin
            safe_we = 1'b1; safe_data = 16'(t * 16'h2D1B + 16'h0E4);
            sw_safe = 1'b1; en = t[0]; swap = t[1];
            tick("R9");
            safe_we = 1'b0;
            tick("R6");
        end
        safe_we = 1'b1; safe_data = 16'h1B1B; tick("R6"); safe_we = 1'b0;

        // R8: clearing the software request leaves safety
        sw_safe = 1'b0; en = 1'b1; tick("R8");

        // R7: shielded trigger is ignored
        hw_shield = 1'b1; hw_trig = 1'b1; tick("R7"); tick("R7");
        // R7: unshielded trigger latches
        hw_shield = 1'b0; tick("R7");
        // R7: raising the shield does not clear the latch
        hw_shield = 1'b1; tick("R7");
        // R8: software request dropped while latched keeps safety on
        sw_safe = 1'b1; tick("R8"); sw_safe = 1'b0; tick("R8");
        // R7: source cleared releases the latch
        hw_trig = 1'b0; tick("R7"); tick("R7");
        hw_shield = 1'b0; hw_trig = 1'b1; tick("R7");
        hw_trig = 1'b0; tick("R7");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule